// File: doc/BRIEF.md
# Woven Spare Lane Reconfiguration Network

This block decides, once per configuration, how a wide SIMD pipeline with a few spare lane components is wired around its defective parts. Every stage holds more physical components than there are logical lanes (one spare per four lanes by default). A component can hand its result to only two neighbours in the next stage: the one directly below it, or the one a single position higher. The resulting routes form a woven pattern of short local links, and no central switch is needed.

A fault map is applied through a load strobe. The map has one bit per physical component per stage, plus two bits for the primary and duplicate copies of the shared fetch/decode unit. The block then walks the stages one per cycle. In each stage it places every logical lane, in order, on the lowest-index working component that the lane can reach. When the walk completes, the block commits the lane map, the link selects and the fetch/decode choice, and pulses a done flag. If some lane cannot be placed, or both fetch/decode copies are bad, the block raises an unrepairable flag and leaves the previous configuration on its outputs.

Top module: `weave_spare_net`

## Requirements
- R1: After reset, every stage maps logical lane i to physical component i, all link selects are 0, the fetch/decode select is 0, and both the done and unrepairable outputs are low.
- R2: In stage 0, lane 0 takes the lowest-index working component. Each later lane takes the lowest-index working component above the one chosen for the lane before it. The component for stage s and lane i is reported in `lane_map_o[(s*LANES+i)*IDXW +: IDXW]`. Within a stage the indices strictly increase with the lane number.
- R3: In a stage s ≥ 1, lane i may use only its stage s-1 component index u (the straight link) or u+1 (the shifted link). It must also use an index above the one chosen for lane i-1 in that stage. The straight link is preferred. Bit `(s-1)*LANES+i` of `hop_sel_o` is 1 exactly when the shifted link is used.
- R4: A committed configuration never places a lane on a failed component. Bit `s*PHYS+p` of `cfg_fault_i` set to 1 marks physical component p of stage s as failed.
- R5: The fetch/decode select is 0 (primary copy) unless `cfg_fd_fault_i[0]` (primary failed) is 1. In that case it is 1 (duplicate copy). `cfg_fd_fault_i[1]` marks the duplicate as failed.
- R6: If any lane cannot be placed in any stage, or both fetch/decode fault bits are 1, the unrepairable flag goes to 1 with the done pulse, and the lane map, link selects and fetch/decode select keep their previous values. A later repairable load clears the flag.
- R7: The done output is high for exactly one cycle. It rises STAGES+1 clock edges after the edge that samples the load strobe, and the new configuration appears on that same edge.
- R8: A load strobe that arrives while a configuration walk is in progress is ignored. The result reflects only the fault map accepted first.
- R9: Between done pulses, the lane map, link selects and fetch/decode select do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load_i | input | 1 | Load strobe; samples the fault inputs when the block is idle |
| cfg_fault_i | input | STAGES*PHYS | Per-component fault bits, bit s*PHYS+p for stage s, component p |
| cfg_fd_fault_i | input | 2 | Fault bits: [0] primary fetch/decode, [1] duplicate |
| lane_map_o | output | STAGES*LANES*IDXW | Physical component index for every stage and logical lane |
| hop_sel_o | output | (STAGES-1)*LANES | Shifted-link select per lane for stages 1 and up |
| fd_sel_o | output | 1 | 0 selects the primary fetch/decode copy, 1 the duplicate |
| cfg_done_o | output | 1 | One-cycle pulse when a configuration walk completes |
| unrepairable_o | output | 1 | Last walk could not route every lane or had no working fetch/decode |

## Verification
A wrong stage-walk state, such as a stale upstream index or a skipped stage, shows up at the done pulse. It appears as a lane index that breaks the straight-or-shifted relation with the stage above it, or as a lane placed on a component the fault map marked as failed. A mistake in the commit path shows up either as outputs that move outside the done cycle or as a changed map beside a raised unrepairable flag. A latency or acceptance fault shows up as the done pulse landing on the wrong edge, or as a second strobe changing the result, within STAGES+1 cycles of the load.

// File: rtl/weave_pkg.sv
package weave_pkg;
  typedef enum logic [1:0] {
    WV_IDLE   = 2'd0,
    WV_SCAN   = 2'd1,
    WV_COMMIT = 2'd2
  } weave_state_t;
endpackage

// File: rtl/weave_stage_router.sv
// Places every logical lane of one stage on a physical component.
module weave_stage_router #(
  parameter int LANES = 8,
  parameter int PHYS  = 10,
  parameter int IDXW  = 4
) (
  input  logic                    first_i,
  input  logic [PHYS-1:0]         fail_i,
  input  logic [LANES*IDXW-1:0]   up_idx_i,
  output logic [LANES*IDXW-1:0]   idx_o,
  output logic [LANES-1:0]        hop_o,
  output logic                    ok_o
);
  always_comb begin
    int floor_v;
    int lo;
    int hi;
    int up;
    int pick;
    logic found;
    idx_o   = '0;
    hop_o   = '0;
    ok_o    = 1'b1;
    floor_v = 0;
    for (int i = 0; i < LANES; i++) begin
      up    = int'(up_idx_i[i*IDXW +: IDXW]);
      lo    = first_i ? floor_v : ((up > floor_v) ? up : floor_v);
      hi    = first_i ? (PHYS - 1) : (up + 1);
      found = 1'b0;
      pick  = lo;
      for (int p = 0; p < PHYS; p++) begin
        if (!found && p >= lo && p <= hi && !fail_i[p]) begin
          found = 1'b1;
          pick  = p;
        end
      end
      if (!found) ok_o = 1'b0;
      idx_o[i*IDXW +: IDXW] = IDXW'(pick);
      hop_o[i] = !first_i && (pick != up);
      floor_v  = pick + 1;
    end
  end
endmodule

// File: rtl/weave_fd_pick.sv
// Chooses between the primary and duplicate fetch/decode copies.
module weave_fd_pick (
  input  logic [1:0] fail_i,
  output logic       sel_o,
  output logic       ok_o
);
  assign sel_o = fail_i[0];
  assign ok_o  = !(fail_i[0] && fail_i[1]);
endmodule

// File: rtl/weave_scan_ctrl.sv
// Walks the stages one per cycle after an accepted load.
module weave_scan_ctrl
  import weave_pkg::*;
#(
  parameter int STAGES = 3,
  parameter int SW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  output logic          idle_o,
  output logic          scan_o,
  output logic          commit_o,
  output logic [SW-1:0] stage_o
);
  weave_state_t state_q;
  logic [SW-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WV_IDLE;
      stage_q <= '0;
    end else begin
      unique case (state_q)
        WV_IDLE: if (load_i) begin
          state_q <= WV_SCAN;
          stage_q <= '0;
        end
        WV_SCAN: if (int'(stage_q) == STAGES - 1) state_q <= WV_COMMIT;
                 else stage_q <= stage_q + 1'b1;
        WV_COMMIT: state_q <= WV_IDLE;
        default: state_q <= WV_IDLE;
      endcase
    end
  end

  assign idle_o   = (state_q == WV_IDLE);
  assign scan_o   = (state_q == WV_SCAN);
  assign commit_o = (state_q == WV_COMMIT);
  assign stage_o  = stage_q;

  p_stage_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_o |-> (int'(stage_o) < STAGES));
endmodule

// File: rtl/weave_spare_net.sv
module weave_spare_net #(
  parameter int LANES     = 8,
  parameter int SPARE_DIV = 4,
  parameter int STAGES    = 3,
  localparam int SPARES   = (LANES + SPARE_DIV - 1) / SPARE_DIV,
  localparam int PHYS     = LANES + SPARES,
  localparam int IDXW     = $clog2(PHYS),
  localparam int FW       = STAGES * PHYS,
  localparam int MW       = STAGES * LANES * IDXW,
  localparam int HW       = (STAGES - 1) * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load_i,
  input  logic [FW-1:0] cfg_fault_i,
  input  logic [1:0]    cfg_fd_fault_i,
  output logic [MW-1:0] lane_map_o,
  output logic [HW-1:0] hop_sel_o,
  output logic          fd_sel_o,
  output logic          cfg_done_o,
  output logic          unrepairable_o
);
  localparam int SW  = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam int LMW = LANES * IDXW;

  logic [FW-1:0]  fault_q;
  logic [1:0]     fdf_q;
  logic           bad_q;
  logic [LMW-1:0] work_map [STAGES];
  logic [LANES-1:0] work_hop [1:STAGES-1];
  logic [MW-1:0]  work_map_flat;
  logic [HW-1:0]  work_hop_flat;
  logic [MW-1:0]  map_q;
  logic [HW-1:0]  hop_q;
  logic           fd_sel_q, done_q, unrep_q;

  logic          idle, scan, commit;
  logic [SW-1:0] stage;
  logic [PHYS-1:0]  row_fail;
  logic [LMW-1:0]   row_up, r_idx;
  logic [LANES-1:0] r_hop;
  logic r_ok, fd_sel_w, fd_ok_w, walk_bad;

  weave_scan_ctrl #(.STAGES(STAGES), .SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load_i),
    .idle_o(idle), .scan_o(scan), .commit_o(commit), .stage_o(stage)
  );

  assign row_fail = fault_q[int'(stage)*PHYS +: PHYS];
  assign row_up   = (stage == '0) ? '0 : work_map[int'(stage) - 1];

  weave_stage_router #(.LANES(LANES), .PHYS(PHYS), .IDXW(IDXW)) u_router (
    .first_i(stage == '0), .fail_i(row_fail), .up_idx_i(row_up),
    .idx_o(r_idx), .hop_o(r_hop), .ok_o(r_ok)
  );

  weave_fd_pick u_fd (.fail_i(fdf_q), .sel_o(fd_sel_w), .ok_o(fd_ok_w));

  assign walk_bad = bad_q || !fd_ok_w;

  for (genvar s = 0; s < STAGES; s++) begin : g_flat
    assign work_map_flat[s*LMW +: LMW] = work_map[s];
    if (s > 0) begin : g_hop
      assign work_hop_flat[(s-1)*LANES +: LANES] = work_hop[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q  <= '0;
      fdf_q    <= '0;
      bad_q    <= 1'b0;
      hop_q    <= '0;
      fd_sel_q <= 1'b0;
      done_q   <= 1'b0;
      unrep_q  <= 1'b0;
      for (int s = 0; s < STAGES; s++) begin
        for (int i = 0; i < LANES; i++) begin
          map_q[(s*LANES+i)*IDXW +: IDXW] <= IDXW'(i);
          work_map[s][i*IDXW +: IDXW]     <= IDXW'(i);
        end
      end
      for (int s = 1; s < STAGES; s++) work_hop[s] <= '0;
    end else begin
      done_q <= commit;
      if (idle && cfg_load_i) begin
        fault_q <= cfg_fault_i;
        fdf_q   <= cfg_fd_fault_i;
        bad_q   <= 1'b0;
      end
      if (scan) begin
        work_map[stage] <= r_idx;
        if (stage != '0) work_hop[stage] <= r_hop;
        if (!r_ok) bad_q <= 1'b1;
      end
      if (commit) begin
        unrep_q <= walk_bad;
        if (!walk_bad) begin
          map_q    <= work_map_flat;
          hop_q    <= work_hop_flat;
          fd_sel_q <= fd_sel_w;
        end
      end
    end
  end

  assign lane_map_o     = map_q;
  assign hop_sel_o      = hop_q;
  assign fd_sel_o       = fd_sel_q;
  assign cfg_done_o     = done_q;
  assign unrepairable_o = unrep_q;

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done_o |=> !cfg_done_o);

  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done_o |-> ($stable(lane_map_o) && $stable(hop_sel_o) && $stable(fd_sel_o)));

  p_keep_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done_o && unrepairable_o) |-> ($stable(lane_map_o) && $stable(fd_sel_o)));

  for (genvar s = 0; s < STAGES; s++) begin : g_chk
    for (genvar i = 1; i < LANES; i++) begin : g_ord
      p_lane_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lane_map_o[(s*LANES+i)*IDXW +: IDXW] > lane_map_o[(s*LANES+i-1)*IDXW +: IDXW]);
    end
    if (s > 0) begin : g_lnk
      for (genvar i = 0; i < LANES; i++) begin : g_l
        p_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
          lane_map_o[(s*LANES+i)*IDXW +: IDXW] ==
          lane_map_o[((s-1)*LANES+i)*IDXW +: IDXW] + IDXW'(hop_sel_o[(s-1)*LANES+i]));
      end
    end
  end
endmodule

// File: tb/weave_spare_net_tb.sv
module weave_spare_net_tb;
  localparam int LANES  = 8;
  localparam int STAGES = 3;
  localparam int PHYS   = LANES + (LANES + 3) / 4;
  localparam int IDXW   = $clog2(PHYS);
  localparam int FW     = STAGES * PHYS;
  localparam int MW     = STAGES * LANES * IDXW;
  localparam int HW     = (STAGES - 1) * LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [FW-1:0] fault = '0;
  logic [1:0] fdf = '0;
  logic [MW-1:0] map_o;
  logic [HW-1:0] hop_o;
  logic fd_sel, done, unrep;

  int checks = 0;
  int fails = 0;
  logic [MW-1:0] e_map;
  logic [HW-1:0] e_hop;
  bit e_sel;

  always #10 clk = ~clk;

  weave_spare_net #(.LANES(LANES), .SPARE_DIV(4), .STAGES(STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load_i(load), .cfg_fault_i(fault),
    .cfg_fd_fault_i(fdf), .lane_map_o(map_o), .hop_sel_o(hop_o),
    .fd_sel_o(fd_sel), .cfg_done_o(done), .unrepairable_o(unrep)
  );

  task automatic chk(input bit good, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [FW-1:0] f, input logic [1:0] fd,
      output logic [MW-1:0] m, output logic [HW-1:0] h, output bit sel, output bit ok);
    int prev [LANES];
    int cur [LANES];
    int nxt;
    int c;
    ok = !(fd[0] && fd[1]);
    sel = fd[0];
    m = '0;
    h = '0;
    for (int i = 0; i < LANES; i++) prev[i] = 0;
    for (int s = 0; s < STAGES; s++) begin
      nxt = 0;
      for (int i = 0; i < LANES; i++) begin
        if (s == 0) begin
          c = nxt;
          while (c < PHYS && f[s*PHYS+c]) c++;
          if (c >= PHYS) begin ok = 0; c = nxt; end
        end else begin
          c = -1;
          if (prev[i] >= nxt && !f[s*PHYS+prev[i]]) c = prev[i];
          else if (prev[i] + 1 < PHYS && prev[i] + 1 >= nxt && !f[s*PHYS+prev[i]+1])
            c = prev[i] + 1;
          if (c < 0) begin ok = 0; c = (prev[i] > nxt) ? prev[i] : nxt; end
          h[(s-1)*LANES+i] = (c != prev[i]);
        end
        cur[i] = c;
        nxt = c + 1;
        m[(s*LANES+i)*IDXW +: IDXW] = IDXW'(c);
      end
      for (int i = 0; i < LANES; i++) prev[i] = cur[i];
    end
  endfunction

  task automatic apply(input logic [FW-1:0] f, input logic [1:0] fd,
                       input bit extra, input logic [FW-1:0] f2);
    logic [MW-1:0] m;
    logic [HW-1:0] h;
    bit sel, ok;
    int n;
    bit used_bad;
    model(f, fd, m, h, sel, ok);
    @(negedge clk);
    load = 1'b1; fault = f; fdf = fd;
    @(negedge clk);
    load = extra; fault = f2; fdf = 2'b00;
    n = 0;
    do begin
      @(negedge clk);
      load = 1'b0;
      n++;
    end while (!done && n < 20);
    chk(n == STAGES + 1, "R7 done latency", 128'(n), 128'(STAGES + 1));
    chk(unrep == !ok, "R6 unrepairable flag", 128'(unrep), 128'(!ok));
    if (ok) begin e_map = m; e_hop = h; e_sel = sel; end
    chk(map_o == e_map, extra ? "R8 map after ignored load" : "R2 lane map",
        128'(map_o), 128'(e_map));
    chk(hop_o == e_hop, "R3 link selects", 128'(hop_o), 128'(e_hop));
    chk(fd_sel == e_sel, "R5 fetch/decode select", 128'(fd_sel), 128'(e_sel));
    if (ok) begin
      used_bad = 0;
      for (int s = 0; s < STAGES; s++)
        for (int i = 0; i < LANES; i++)
          if (f[s*PHYS + int'(map_o[(s*LANES+i)*IDXW +: IDXW])]) used_bad = 1;
      chk(!used_bad, "R4 no failed component used", 128'(used_bad), 128'(0));
    end
    @(negedge clk);
    chk(!done, "R7 done one cycle", 128'(done), 128'(0));
    repeat (2) @(negedge clk);
    chk(map_o == e_map && hop_o == e_hop, "R9 outputs hold", 128'(map_o), 128'(e_map));
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [FW-1:0] f;
    logic [MW-1:0] ident;
    void'($urandom(32'd20240611));
    for (int s = 0; s < STAGES; s++)
      for (int i = 0; i < LANES; i++) ident[(s*LANES+i)*IDXW +: IDXW] = IDXW'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(map_o == ident, "R1 reset map", 128'(map_o), 128'(ident));
    chk(hop_o == '0 && fd_sel == 1'b0, "R1 reset selects", 128'({hop_o, fd_sel}), 128'(0));
    chk(!done && !unrep, "R1 reset flags", 128'({done, unrep}), 128'(0));
    e_map = ident; e_hop = '0; e_sel = 0;

    apply('0, 2'b00, 0, '0);                      // R2 clean map
    f = '0; f[0] = 1'b1;                           // R2 stage 0 shift
    apply(f, 2'b01, 0, '0);                        // R5 duplicate copy
    f = '0; f[PHYS+3] = 1'b1; f[PHYS+4] = 1'b1;    // R6 lane 3 blocked in stage 1
    apply(f, 2'b00, 0, '0);
    apply('0, 2'b11, 0, '0);                       // R6 both fetch/decode bad
    f = '0; f[2*PHYS+5] = 1'b1;                    // R3 shifted links, clears R6 flag
    apply(f, 2'b10, 0, '0);
    f = '0; f[1] = 1'b1;                           // R8 second strobe ignored
    apply('0, 2'b00, 1, f);
    f = '0; f[PHYS-1] = 1'b1; f[2*PHYS-1] = 1'b1;  // top spares failed
    apply(f, 2'b00, 0, '0);

    for (int k = 0; k < 60; k++) begin
      f = '0;
      for (int b = 0; b < FW; b++) if ($urandom % 10 == 0) f[b] = 1'b1;
      apply(f, 2'($urandom % 4 == 0 ? $urandom : 0), 0, '0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule